// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the control logic of a byte-organised memory that answers as a slave on a two-wire serial bus. A system clock samples the clock and data lines. The block finds START and STOP conditions, decodes a select byte and a two-byte word address, and then reads or writes a 4096-byte on-chip array. The array reads as FFh in every location until a location is first written.

A write carries one data byte or a burst of data bytes. A burst wraps inside a 32-byte page. A level on the write-lock input refuses data bytes while select and address bytes are still accepted. After a STOP that ends a write that stored at least one byte, the block runs a programming interval that a counter times. During that interval it stays silent to its own select code, so a master can poll until it gets an acknowledge. A read starts either at the internal address pointer or at an address set by a dummy write followed by a repeated START. The read goes on byte after byte for as long as the master acknowledges.

There is no streaming data port. All traffic passes over the serial lines, so no valid/ready handshake or back-pressure applies. The data line is open-drain: `sda_oe_o` high means that the block pulls the line low.

Top module: `twire_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. A STOP returns the block to standby with the data line released, and a later START with a valid select byte is accepted again.
- R2: The first byte after a START is the select byte, sent MSB first. Bits 7..4 must be 1010b. Bits 3..1 must equal `chip_en_i[2:0]`. Bit 0 is 1 for a read and 0 for a write. On any mismatch the block does not acknowledge and ignores the bus until the next START.
- R3: For every byte it accepts, the block pulls the data line low during the 9th clock pulse.
- R4: A write sends the word address as two bytes, high byte first. Only the low 12 bits are used, and the upper 4 bits of the high byte are don't-care. A single data byte that follows is stored at that address.
- R5: In a burst write the low 5 address bits advance and the upper 7 bits stay fixed. Bytes past the end of a 32-byte page wrap to the page start.
- R6: While `wr_lock_i` is high, select and address bytes are acknowledged and data bytes are not. The array is left unchanged and no programming interval starts.
- R7: A STOP after a write that stored at least one byte starts a programming interval of `PROG_CYCLES` clocks. During the interval the select byte is not acknowledged. Once the interval has passed, the select byte is acknowledged again.
- R8: A random read, made of a dummy write of select and address followed by a repeated START and a read select, returns the byte at the given address.
- R9: A read select with no address phase returns the byte at the internal pointer. That pointer is the last accessed address plus one.
- R10: A sequential read returns consecutive bytes while the master acknowledges each one. The read address runs across the whole array and wraps from FFFh to 000h.
- R11: When the master leaves the data line high on the 9th clock of a read byte, the block releases the line and returns to standby. It also keeps the line released during every master-acknowledge slot.
- R12: After reset the data line is released and every array byte reads as FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls the data line low |
| chip_en_i | input | 3 | Strap value compared with select bits 3..1 |
| wr_lock_i | input | 1 | High refuses data bytes of writes |

## Verification
The bound checker watches on every cycle that a STOP always leads to a released line in standby. It also checks that a select byte with a wrong type code, or one that arrives during programming, gets no acknowledge, and that a locked data byte gets none either. It further checks that the page bits of the address never move on a stored byte, and that the line is free in standby and in every master-acknowledge slot. Stored contents can only be shown by the bench's scenarios: a full sweep of the strap codes, byte and page writes with wrap, reads by pointer, by random address and in sequence, including the wrap at the array end, polling through the programming interval, and a locked write followed by a read-back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else if (g == 0) begin
        scl_pipe[g] <= scl_i;
        sda_pipe[g] <= sda_i;
      end else begin
        scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
        sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_pipe[STAGES-1] & ~scl_prev;
  assign scl_fall = ~scl_pipe[STAGES-1] & scl_prev;
  assign start_ev = scl_pipe[STAGES-1] & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_pipe[STAGES-1] & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  filled;

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  assign rdata = filled[raddr] ? cells[raddr] : {DATA_W{1'b1}};
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (kick)           remain <= CNT_W'(PROG_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/twire_eeprom_slave.sv
module twire_eeprom_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_en_i,
  input  logic       wr_lock_i
);
  import eep_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_lvl;
  logic busy, prog_kick, mem_we;
  logic [7:0] rd_data;

  eep_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   hi_q;
  logic              sda_oe_q, wrote_q, read_q, mack_q;

  logic ack_slot, end_slot, sel_ok;
  logic [ADDR_W-1:0] addr_inc, addr_page_inc;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(sda_lvl)
  );

  eep_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr_q),
    .wdata(sh_q), .raddr(addr_q), .rdata(rd_data)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(prog_kick), .busy(busy)
  );

  always_comb begin
    ack_slot      = scl_fall && (bit_cnt_q == 4'd8) && (state_q != ST_IDLE)
                    && !start_ev && !stop_ev;
    end_slot      = scl_fall && (bit_cnt_q == 4'd9) && (state_q != ST_IDLE)
                    && !start_ev && !stop_ev;
    sel_ok        = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:1] == chip_en_i) && !busy;
    mem_we        = ack_slot && (state_q == ST_WDATA) && !wr_lock_i;
    prog_kick     = stop_ev && wrote_q;
    addr_inc      = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    addr_page_inc = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      hi_q      <= '0;
      sda_oe_q  <= 1'b0;
      wrote_q   <= 1'b0;
      read_q    <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_DEVSEL;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else if (stop_ev) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      wrote_q   <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q < 4'd8) begin
          if (state_q != ST_RDATA) sh_q <= {sh_q[6:0], sda_lvl};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (bit_cnt_q == 4'd8) begin
          bit_cnt_q <= 4'd9;
          mack_q    <= ~sda_lvl;
        end
      end else if (ack_slot) begin
        case (state_q)
          ST_DEVSEL: begin
            if (sel_ok) begin
              sda_oe_q <= 1'b1;
              read_q   <= sh_q[0];
            end else begin
              state_q   <= ST_IDLE;
              bit_cnt_q <= '0;
              sda_oe_q  <= 1'b0;
            end
          end
          ST_ADDR_HI: begin
            hi_q     <= sh_q[HI_W-1:0];
            sda_oe_q <= 1'b1;
          end
          ST_ADDR_LO: begin
            addr_q   <= {hi_q, sh_q};
            sda_oe_q <= 1'b1;
          end
          ST_WDATA: begin
            if (!wr_lock_i) begin
              sda_oe_q <= 1'b1;
              addr_q   <= addr_page_inc;
              wrote_q  <= 1'b1;
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
          default: sda_oe_q <= 1'b0;
        endcase
      end else if (end_slot) begin
        bit_cnt_q <= '0;
        case (state_q)
          ST_DEVSEL: begin
            if (read_q) begin
              state_q  <= ST_RDATA;
              sh_q     <= rd_data;
              addr_q   <= addr_inc;
              sda_oe_q <= ~rd_data[7];
            end else begin
              state_q  <= ST_ADDR_HI;
              sda_oe_q <= 1'b0;
            end
          end
          ST_ADDR_HI: begin
            state_q  <= ST_ADDR_LO;
            sda_oe_q <= 1'b0;
          end
          ST_ADDR_LO: begin
            state_q  <= ST_WDATA;
            sda_oe_q <= 1'b0;
          end
          ST_RDATA: begin
            if (mack_q) begin
              sh_q     <= rd_data;
              addr_q   <= addr_inc;
              sda_oe_q <= ~rd_data[7];
            end else begin
              state_q  <= ST_IDLE;
              sda_oe_q <= 1'b0;
            end
          end
          default: sda_oe_q <= 1'b0;
        endcase
      end else if (scl_fall && (state_q == ST_RDATA) && (bit_cnt_q != 4'd0)
                   && (bit_cnt_q < 4'd8)) begin
        sh_q     <= {sh_q[6:0], 1'b1};
        sda_oe_q <= ~sh_q[6];
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input eep_pkg::eep_state_e state,
  input logic [3:0]          bit_cnt,
  input logic [7:0]          rx_byte,
  input logic [ADDR_W-1:0]   addr,
  input logic                scl_fall,
  input logic                start_ev,
  input logic                stop_ev,
  input logic                busy,
  input logic                wr_lock,
  input logic                mem_we,
  input logic                sda_oe
);
  import eep_pkg::*;

  // R1
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (state == ST_IDLE && !sda_oe));

  // R2
  bad_code_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEVSEL && scl_fall && bit_cnt == 4'd8 && !start_ev && !stop_ev
     && rx_byte[7:4] != TYPE_CODE) |=> !sda_oe);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

  // R6
  lock_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA && scl_fall && bit_cnt == 4'd8 && !start_ev && !stop_ev
     && wr_lock) |=> !sda_oe);

  // R7
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEVSEL && scl_fall && bit_cnt == 4'd8 && busy) |=> !sda_oe);

  // R11
  master_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && bit_cnt == 4'd9) |-> !sda_oe);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

bind twire_eeprom_slave eep_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .bit_cnt(bit_cnt_q),
  .rx_byte(sh_q), .addr(addr_q), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .busy(busy), .wr_lock(wr_lock_i), .mem_we(mem_we),
  .sda_oe(sda_oe_o)
);

// File: tb/tb_twire_eeprom_slave.sv
module tb_twire_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_lock = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  twire_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .chip_en_i(STRAP), .wr_lock_i(wr_lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic seen);
    wq(); sda_m = b; wq(); scl = 1'b1; wq(); seen = sda_bus; wq(); scl = 1'b0;
  endtask

  task automatic bus_start();
    wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      b[i] = s;
    end
    bit_clk(~mack, s);
  endtask

  function automatic logic [7:0] sel(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    logic a;
    bus_start();
    send_byte(sel(1'b0), a); chk({tag, " select ack"}, a, 1);
    send_byte(hi, a);        chk({tag, " addr hi ack"}, a, 1);
    send_byte(lo, a);        chk({tag, " addr lo ack"}, a, 1);
  endtask

  task automatic poll_ready(output int polls);
    logic a;
    polls = 0;
    a = 1'b0;
    while (!a && polls < 200) begin
      bus_start();
      send_byte(sel(1'b0), a);
      bus_stop();
      polls++;
    end
  endtask

  task automatic write_burst(input logic [11:0] base, input int n, input int seed, input string tag);
    logic a;
    logic [11:0] p;
    int polls;
    set_addr({4'hF, base[11:8]}, base[7:0], tag);
    p = base;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(i * 8'h11 + seed);
      send_byte(d, a);
      chk({tag, " data ack"}, a, 1);
      model[p] = d;
      p = {p[11:5], p[4:0] + 5'd1};
    end
    bus_stop();
    poll_ready(polls);
    chk({tag, " R7 first poll refused"}, int'(polls > 1), 1);
    chk({tag, " R7 ready after interval"}, int'(polls < 200), 1);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int polls;
    for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    chk("R12 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 released after reset", sda_oe, 0);

    // R2: sweep every strap code plus two wrong type codes
    for (int c = 0; c < 8; c++) begin
      bus_start();
      send_byte({4'b1010, 3'(c), 1'b0}, a);
      chk($sformatf("R2 strap %0d ack", c), a, int'(3'(c) == STRAP));
      bus_stop();
    end
    for (int t = 0; t < 2; t++) begin
      bus_start();
      send_byte({(t == 0) ? 4'b1011 : 4'b0010, STRAP, 1'b0}, a);
      chk("R2 wrong type code nak", a, 0);
      bus_stop();
    end

    // R3/R4/R7: single byte write, upper address bits don't-care
    write_burst(12'h123, 1, 8'h5A, "R4 byte write");

    // R8: random read; R11: NAK releases
    set_addr(8'h01, 8'h23, "R8");
    bus_start();
    send_byte(sel(1'b1), a); chk("R8 read select ack", a, 1);
    recv_byte(1'b0, d);      chk("R8 random read data", d, model[12'h123]);
    chk("R11 line released after nak", sda_oe, 0);
    bus_stop();

    // R9: current address read gets last + 1
    bus_start();
    send_byte(sel(1'b1), a); chk("R9 read select ack", a, 1);
    recv_byte(1'b0, d);      chk("R9 current read 0x124", d, model[12'h124]);
    bus_stop();

    // R5: burst crossing the page end wraps
    write_burst(12'h33E, 6, 8'h07, "R5 page write");
    chk("R5 wrap landed at page start", model[12'h320], 8'h29);

    // R10: sequential read of the whole page
    set_addr(8'h03, 8'h20, "R10");
    bus_start();
    send_byte(sel(1'b1), a); chk("R10 read select ack", a, 1);
    for (int i = 0; i < 32; i++) begin
      recv_byte(i != 31, d);
      chk($sformatf("R10 page byte %0d", i), d, model[12'h320 + i]);
    end
    bus_stop();
    bus_start();
    send_byte(sel(1'b1), a);
    recv_byte(1'b0, d);      chk("R9 pointer after page read", d, model[12'h340]);
    bus_stop();

    // R6: locked write
    wr_lock = 1'b1;
    set_addr(8'h02, 8'h00, "R6 locked");
    send_byte(8'h77, a);     chk("R6 data nak", a, 0);
    bus_stop();
    wr_lock = 1'b0;
    bus_start();
    send_byte(sel(1'b0), a); chk("R6 no programming interval", a, 1);
    bus_stop();
    set_addr(8'h02, 8'h00, "R6 readback");
    bus_start();
    send_byte(sel(1'b1), a);
    recv_byte(1'b0, d);      chk("R6 array unchanged", d, 8'hFF);
    bus_stop();

    // R10: read wraps from array end to start
    write_burst(12'h000, 1, 8'hC3, "R10 seed");
    set_addr(8'h0F, 8'hFE, "R10 wrap");
    bus_start();
    send_byte(sel(1'b1), a);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d);
      chk($sformatf("R10 wrap byte %0d", i), d, model[12'((12'hFFE + i) % 4096)]);
    end
    bus_stop();

    // R1: STOP in the middle of an address phase, then a fresh transfer
    bus_start();
    send_byte(sel(1'b0), a);
    send_byte(8'h00, a);
    bus_stop();
    chk("R1 released after stop", sda_oe, 0);
    bus_start();
    send_byte(sel(1'b0), a); chk("R1 accepted after stop", a, 1);
    bus_stop();
    chk("R12 never-written byte", model[12'h7AB], 8'hFF);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule